// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block lets an external host program a bank of 8-bit configuration registers over a two-wire serial bus of the I2C kind. Both bus lines are oversampled in the system clock domain. They pass through a two-flop synchronizer and an optional pulse-rejection filter, and START and STOP are detected from the cleaned levels. The slave drives the data line only by pulling it low, through an open-drain enable output.

A transfer opens with a device-address byte. The seven address bits are a fixed six-bit prefix followed by the level of an address-select pin, and the R/W flag comes last. In a write transfer the next byte sets a register pointer, and every later byte is stored at the pointer, which then moves up by one. A read transfer returns bytes starting at the pointer. The usual way to read is a write of the pointer, then a repeated START with the read flag. Four consecutive registers form a group whose 32-bit value is handed to the rest of the chip only when the last byte of the group is written. Chip logic reads any register through a combinational side port.

Top module: `i2c_cfg_slave`

## Requirements
- R1: The slave answers only when the first byte after START carries address bits [7:1] equal to {6'b110101, addr_sel}. Bit 0 is the direction, 0 for write and 1 for read. Any other address gets no acknowledge, and the bus is ignored until the next START.
- R2: Bytes are taken MSB first. The slave acknowledges a byte by asserting sda_oe (pulling SDA low) for the ninth SCL pulse of the address, pointer and write-data bytes, and releases it after that pulse.
- R3: In a write transfer the second byte loads the register pointer. A value of NUM_REGS or more is not acknowledged, sends the slave back to idle and leaves the pointer unchanged.
- R4: Each write-data byte is stored in the register the pointer selects, and the pointer then moves up by one.
- R5: After the top register (NUM_REGS-1) has been written in a burst, a further byte is not stored and not acknowledged, and the slave goes idle.
- R6: A read returns the register at the pointer and moves the pointer up after each byte. An acknowledge from the master (SDA low on the ninth pulse) asks for the next byte, and a no-acknowledge ends the read. Once past the top, the top register is returned again and again.
- R7: A repeated START keeps the pointer, so a pointer write followed by a read transfer returns data from the pointer just written.
- R8: A START or a STOP at any bit position aborts the current transfer at once and releases SDA. A byte that was not completed is not stored.
- R9: Registers GRP_BASE..GRP_BASE+3 form a group, with GRP_BASE as the least significant byte. Writes to them land in the registers at once, but grp_value changes only when GRP_BASE+3 is written, and then takes all four bytes.
- R10: With addr_sel low, a pulse on SCL or SDA shorter than FILT_LEN clock cycles is rejected. With addr_sel high, only the synchronizer is in the path, so a pulse of a few cycles acts as a real edge.
- R11: cfg_data shows register cfg_idx combinationally, and 0 when cfg_idx is NUM_REGS or more.
- R12: After reset all registers and grp_value are 0 and sda_oe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level as seen on the wire |
| addr_sel | input | 1 | Address bit 1. When low, also turns on the pulse filter |
| sda_oe | output | 1 | When high, the pad pulls SDA low |
| cfg_idx | input | 8 | Register index for the side read port |
| cfg_data | output | 8 | Contents of register cfg_idx |
| grp_value | output | 32 | Committed value of the four-register group |

## Verification
The bench builds the block with its defaults: 16 registers, the group at indices 8 to 11, and a 7-cycle filter. With these values the top register and the out-of-range pointers (16 and 200) can be reached in a few bytes, and a filter of 7 cycles at 8 ns per cycle rejects pulses up to about 50 ns. A 3-cycle SCL pulse is injected in both filter settings. With the filter on the byte must be stored intact. With it off, the extra edge must shift the captured byte to a value the bench works out in advance. Random bursts from a fixed seed, in either filter mode and sometimes with invalid pointers, are compared with a bench-side register model.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ACK_ADDR,
      ST_SUB,
      ST_ACK_SUB,
      ST_WDATA,
      ST_ACK_W,
      ST_RDATA,
      ST_ACK_R
   } slv_state_e;

   typedef struct packed {
      logic start;
      logic stop;
      logic scl_rise;
      logic scl_fall;
      logic scl;
      logic sda;
   } bus_evt_t;

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
   parameter int FILT_LEN = 7
) (
   input  logic clk,
   input  logic rst_n,
   input  logic filt_en,
   input  logic raw_i,
   output logic line_o
);
   localparam int CNT_W = (FILT_LEN > 0) ? $clog2(FILT_LEN + 1) : 1;

   logic [1:0] sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= 2'b11;
      else        sync_q <= {sync_q[0], raw_i};
   end

   generate
      if (FILT_LEN == 0) begin : g_bypass
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) line_o <= 1'b1;
            else        line_o <= sync_q[1];
         end
      end else begin : g_filter
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               line_o <= 1'b1;
               cnt_q  <= '0;
            end else if (sync_q[1] == line_o) begin
               cnt_q <= '0;
            end else if (!filt_en || cnt_q == CNT_W'(FILT_LEN - 1)) begin
               line_o <= sync_q[1];
               cnt_q  <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
         // R10: with the filter on, an accepted change follows a run of differing samples
         assert_filter_run_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (filt_en && $past(filt_en) && (line_o != $past(line_o))) |-> ($past(sync_q[1]) != $past(line_o)));
      end
   endgenerate
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events
   import i2c_cfg_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     scl_f,
   input  logic     sda_f,
   output bus_evt_t evt
);
   logic scl_d, sda_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_f;
         sda_d <= sda_f;
      end
   end

   always_comb begin
      evt.scl      = scl_f;
      evt.sda      = sda_f;
      evt.scl_rise = scl_f & ~scl_d;
      evt.scl_fall = ~scl_f & scl_d;
      evt.start    = scl_f & scl_d & sda_d & ~sda_f;
      evt.stop     = scl_f & scl_d & ~sda_d & sda_f;
   end
endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
   import i2c_cfg_pkg::*;
#(
   parameter int         NUM_REGS    = 16,
   parameter logic [5:0] DEV_ADDR_HI = 6'b110101,
   parameter int         IDX_W       = $clog2(NUM_REGS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  bus_evt_t         evt,
   input  logic             dev_sel,
   input  logic [7:0]       rd_byte,
   output logic             sda_oe,
   output logic [IDX_W-1:0] ptr,
   output logic             wr_en,
   output logic [IDX_W-1:0] wr_idx,
   output logic [7:0]       wr_data
);
   localparam logic [IDX_W-1:0] TOP = IDX_W'(NUM_REGS - 1);

   slv_state_e state;
   logic [3:0] bitcnt;
   logic [7:0] shreg, txreg;
   logic       rw, over, mack;
   logic       byte_done;

   assign byte_done = evt.scl_fall && (bitcnt == 4'd8);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         bitcnt  <= '0;
         shreg   <= '0;
         txreg   <= '0;
         sda_oe  <= 1'b0;
         rw      <= 1'b0;
         over    <= 1'b0;
         mack    <= 1'b0;
         ptr     <= '0;
         wr_en   <= 1'b0;
         wr_idx  <= '0;
         wr_data <= '0;
      end else begin
         wr_en <= 1'b0;
         if (evt.start) begin
            state  <= ST_ADDR;
            bitcnt <= '0;
            sda_oe <= 1'b0;
         end else if (evt.stop) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
         end else begin
            case (state)
               ST_ADDR, ST_SUB, ST_WDATA: begin
                  if (evt.scl_rise) begin
                     shreg  <= {shreg[6:0], evt.sda};
                     bitcnt <= bitcnt + 1'b1;
                  end else if (byte_done) begin
                     bitcnt <= '0;
                     state  <= ST_IDLE;
                     if (state == ST_ADDR) begin
                        if (shreg[7:1] == {DEV_ADDR_HI, dev_sel}) begin
                           rw     <= shreg[0];
                           sda_oe <= 1'b1;
                           state  <= ST_ACK_ADDR;
                        end
                     end else if (state == ST_SUB) begin
                        if (int'(shreg) < NUM_REGS) begin
                           ptr    <= shreg[IDX_W-1:0];
                           over   <= 1'b0;
                           sda_oe <= 1'b1;
                           state  <= ST_ACK_SUB;
                        end
                     end else if (!over) begin
                        wr_en   <= 1'b1;
                        wr_idx  <= ptr;
                        wr_data <= shreg;
                        sda_oe  <= 1'b1;
                        state   <= ST_ACK_W;
                        if (ptr == TOP) over <= 1'b1;
                        else            ptr  <= ptr + 1'b1;
                     end
                  end
               end
               ST_ACK_ADDR: begin
                  if (evt.scl_fall) begin
                     bitcnt <= '0;
                     if (rw) begin
                        state  <= ST_RDATA;
                        txreg  <= rd_byte;
                        sda_oe <= ~rd_byte[7];
                     end else begin
                        state  <= ST_SUB;
                        sda_oe <= 1'b0;
                     end
                  end
               end
               ST_ACK_SUB, ST_ACK_W: begin
                  if (evt.scl_fall) begin
                     sda_oe <= 1'b0;
                     bitcnt <= '0;
                     state  <= ST_WDATA;
                  end
               end
               ST_RDATA: begin
                  if (evt.scl_rise) begin
                     bitcnt <= bitcnt + 1'b1;
                  end else if (byte_done) begin
                     sda_oe <= 1'b0;
                     state  <= ST_ACK_R;
                     if (ptr == TOP) over <= 1'b1;
                     else            ptr  <= ptr + 1'b1;
                  end else if (evt.scl_fall) begin
                     txreg  <= {txreg[6:0], 1'b0};
                     sda_oe <= ~txreg[6];
                  end
               end
               ST_ACK_R: begin
                  if (evt.scl_rise) begin
                     mack <= ~evt.sda;
                  end else if (evt.scl_fall) begin
                     bitcnt <= '0;
                     if (mack) begin
                        state  <= ST_RDATA;
                        txreg  <= rd_byte;
                        sda_oe <= ~rd_byte[7];
                     end else begin
                        state <= ST_IDLE;
                     end
                  end
               end
               default: sda_oe <= 1'b0;
            endcase
         end
      end
   end

   // R8: a START restarts address capture with SDA released
   assert_start_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
      evt.start |=> (state == ST_ADDR && !sda_oe));
   // R8: a STOP returns to idle with SDA released
   assert_stop_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
      evt.stop |=> (state == ST_IDLE && !sda_oe));
   // R2: the slave changes SDA to low only while SCL is low
   assert_drive_scl_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !evt.scl);
   // R4: every stored byte is acknowledged in the same cycle
   assert_write_acked_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> sda_oe);
   // R5: a byte past the top register is neither stored nor acknowledged
   assert_no_store_past_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WDATA && over && byte_done) |=> (!wr_en && !sda_oe && state == ST_IDLE));
endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank #(
   parameter int NUM_REGS = 16,
   parameter int GRP_BASE = 8,
   parameter int IDX_W    = $clog2(NUM_REGS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [7:0]       wr_data,
   input  logic [IDX_W-1:0] bus_idx,
   output logic [7:0]       bus_data,
   input  logic [7:0]       host_idx,
   output logic [7:0]       host_data,
   output logic [31:0]      grp_value
);
   localparam logic [IDX_W-1:0] GRP_TOP = IDX_W'(GRP_BASE + 3);

   logic [7:0] regs [NUM_REGS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
         grp_value <= '0;
      end else if (wr_en) begin
         regs[wr_idx] <= wr_data;
         if (wr_idx == GRP_TOP)
            grp_value <= {wr_data, regs[GRP_BASE+2], regs[GRP_BASE+1], regs[GRP_BASE]};
      end
   end

   always_comb begin
      bus_data  = '0;
      host_data = '0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (bus_idx == IDX_W'(i))  bus_data  = regs[i];
         if (host_idx == 8'(i))     host_data = regs[i];
      end
   end

   // R9: the group value moves only on a write to the group's last byte
   assert_grp_commit_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_idx == GRP_TOP) |=> $stable(grp_value));
endmodule

// File: rtl/i2c_cfg_slave.sv
module i2c_cfg_slave
   import i2c_cfg_pkg::*;
#(
   parameter int         NUM_REGS    = 16,
   parameter int         GRP_BASE    = 8,
   parameter int         FILT_LEN    = 7,
   parameter logic [5:0] DEV_ADDR_HI = 6'b110101
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        scl_i,
   input  logic        sda_i,
   input  logic        addr_sel,
   output logic        sda_oe,
   input  logic [7:0]  cfg_idx,
   output logic [7:0]  cfg_data,
   output logic [31:0] grp_value
);
   localparam int IDX_W = $clog2(NUM_REGS);

   generate
      if (NUM_REGS < 5 || NUM_REGS > 256) begin : g_bad_regs
         $error("NUM_REGS must lie in 5..256");
      end
      if (GRP_BASE < 0 || GRP_BASE + 4 > NUM_REGS) begin : g_bad_grp
         $error("register group must fit inside the bank");
      end
      if (FILT_LEN < 0 || FILT_LEN > 1024) begin : g_bad_filt
         $error("FILT_LEN must lie in 0..1024");
      end
   endgenerate

   logic [1:0] raw_lines, clean_lines;
   assign raw_lines = {sda_i, scl_i};

   generate
      for (genvar g = 0; g < 2; g++) begin : g_line
         i2c_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .filt_en(~addr_sel),
            .raw_i  (raw_lines[g]),
            .line_o (clean_lines[g])
         );
      end
   endgenerate

   bus_evt_t         evt;
   logic [IDX_W-1:0] ptr, wr_idx;
   logic             wr_en;
   logic [7:0]       wr_data, bus_data;

   i2c_bus_events u_evt (
      .clk  (clk),
      .rst_n(rst_n),
      .scl_f(clean_lines[0]),
      .sda_f(clean_lines[1]),
      .evt  (evt)
   );

   i2c_slave_fsm #(
      .NUM_REGS   (NUM_REGS),
      .DEV_ADDR_HI(DEV_ADDR_HI),
      .IDX_W      (IDX_W)
   ) u_fsm (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt    (evt),
      .dev_sel(addr_sel),
      .rd_byte(bus_data),
      .sda_oe (sda_oe),
      .ptr    (ptr),
      .wr_en  (wr_en),
      .wr_idx (wr_idx),
      .wr_data(wr_data)
   );

   i2c_reg_bank #(
      .NUM_REGS(NUM_REGS),
      .GRP_BASE(GRP_BASE),
      .IDX_W   (IDX_W)
   ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .wr_data  (wr_data),
      .bus_idx  (ptr),
      .bus_data (bus_data),
      .host_idx (cfg_idx),
      .host_data(cfg_data),
      .grp_value(grp_value)
   );

   // R12: nothing is driven onto SDA while in reset
   always_comb begin
      if (!rst_n) assert_reset_release_R12: assert (!sda_oe);
   end
endmodule

// File: tb/i2c_cfg_slave_bench.sv
module i2c_cfg_slave_bench;
   localparam int NREGS = 16;
   localparam int GBASE = 8;
   localparam int Q     = 12;

   typedef logic [7:0] bytes_t [8];

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scl_m = 1'b1, sda_m = 1'b1, scl_g = 1'b0, sda_g = 1'b0;
   logic        addr_sel = 1'b1;
   logic        sda_oe;
   logic [7:0]  cfg_idx = '0;
   logic [7:0]  cfg_data;
   logic [31:0] grp_value;
   logic        sda_line, scl_line;

   assign sda_line = sda_m & ~sda_g & ~sda_oe;
   assign scl_line = scl_m | scl_g;

   always #4 clk = ~clk;

   i2c_cfg_slave u_i2c_cfg_slave (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
      .addr_sel(addr_sel), .sda_oe(sda_oe), .cfg_idx(cfg_idx),
      .cfg_data(cfg_data), .grp_value(grp_value)
   );

   int         n_chk = 0, n_bad = 0;
   bit         done = 1'b0;
   logic [7:0] model [NREGS];
   logic [31:0] model_grp = '0;

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] dev_byte(input bit rd);
      return {6'b110101, addr_sel, rd};
   endfunction

   // expected ack pattern: bit0 address, bit1 pointer, bit 2+i data byte i
   function automatic logic [9:0] model_wr(input logic [7:0] sub, input int n, input bytes_t d);
      logic [9:0] a;
      int p;
      a = 10'b1;
      if (int'(sub) >= NREGS) return a;
      a[1] = 1'b1;
      p = int'(sub);
      for (int i = 0; i < n; i++) begin
         if (p > NREGS - 1) break;
         model[p] = d[i];
         if (p == GBASE + 3) model_grp = {d[i], model[GBASE+2], model[GBASE+1], model[GBASE]};
         a[2+i] = 1'b1;
         p++;
      end
      return a;
   endfunction

   function automatic logic [7:0] model_rd(input int p);
      return model[(p > NREGS - 1) ? NREGS - 1 : p];
   endfunction

   task automatic i_start();
      sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
   endtask

   task automatic i_stop();
      sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
   endtask

   // gl: 0 none, 1 short SCL pulse in the low phase, 2 short SDA dip in the high phase
   task automatic send_bit(input logic b, input int gl);
      sda_m = b;
      if (gl == 1) begin
         tick(4); scl_g = 1'b1; tick(3); scl_g = 1'b0; tick(Q - 7);
      end else tick(Q);
      scl_m = 1'b1;
      if (gl == 2) begin
         tick(Q / 2); sda_g = 1'b1; tick(4); sda_g = 1'b0; tick(2 * Q - Q / 2 - 4);
      end else tick(2 * Q);
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic recv_bit(output logic b);
      sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); b = sda_line; tick(Q); scl_m = 1'b0; tick(Q);
   endtask

   task automatic wr_byte_g(input logic [7:0] d, input int gl, output logic ack);
      logic x;
      for (int i = 7; i >= 0; i--) send_bit(d[i], (i == 7) ? gl : 0);
      recv_bit(x);
      ack = ~x;
   endtask

   task automatic wr_byte(input logic [7:0] d, output logic ack);
      wr_byte_g(d, 0, ack);
   endtask

   task automatic rd_byte(input logic mack, output logic [7:0] d);
      logic x;
      for (int i = 7; i >= 0; i--) begin recv_bit(x); d[i] = x; end
      send_bit(~mack, 0);
   endtask

   task automatic do_write(input logic [7:0] sub, input int n, input bytes_t d, output logic [9:0] acks);
      logic a;
      acks = '0;
      i_start();
      wr_byte(dev_byte(1'b0), a); acks[0] = a;
      if (a) begin
         wr_byte(sub, a); acks[1] = a;
         if (a) begin
            for (int i = 0; i < n; i++) begin
               wr_byte(d[i], a); acks[2+i] = a;
               if (!a) break;
            end
         end
      end
      i_stop();
   endtask

   task automatic do_read(input logic [7:0] sub, input int n, output bytes_t q);
      logic a;
      i_start();
      wr_byte(dev_byte(1'b0), a);
      wr_byte(sub, a);
      i_start();
      wr_byte(dev_byte(1'b1), a);
      for (int i = 0; i < n; i++) rd_byte(i < n - 1, q[i]);
      i_stop();
   endtask

   task automatic check_bank(input string req);
      for (int i = 0; i < NREGS; i++) begin
         cfg_idx = 8'(i); tick(1);
         check(req, {24'b0, cfg_data}, {24'b0, model[i]});
      end
      check(req, grp_value, model_grp);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      bytes_t     d, q;
      logic [9:0] acks, eacks;
      logic       a;
      void'($urandom(32'd2024));
      for (int i = 0; i < NREGS; i++) model[i] = '0;
      tick(5);
      // R12: reset state
      check("R12 sda_oe in reset", {31'b0, sda_oe}, 32'h0);
      rst_n = 1'b1; tick(5);
      cfg_idx = 8'd3; tick(1);
      check("R12 register after reset", {24'b0, cfg_data}, 32'h0);
      check("R12 group after reset", grp_value, 32'h0);

      // R1: foreign address and address with the other select level
      i_start(); wr_byte(8'b1101_0010, a); i_stop();
      check("R1 foreign address nack", {31'b0, a}, 32'h0);
      i_start(); wr_byte({6'b110101, 1'b0, 1'b0}, a); i_stop();
      check("R1 select-bit mismatch nack", {31'b0, a}, 32'h0);

      // R2 R4: burst write with auto-increment
      d = '{8'h11, 8'h22, 8'h33, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
      eacks = model_wr(8'd2, 3, d);
      do_write(8'd2, 3, d, acks);
      check("R2 R4 burst acks", {22'b0, acks}, {22'b0, eacks});
      check_bank("R4 burst contents");

      // R9: partial group, then the last byte
      d = '{8'hA1, 8'hB2, 8'hC3, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
      eacks = model_wr(8'(GBASE), 3, d);
      do_write(8'(GBASE), 3, d, acks);
      check("R9 group unchanged before last byte", grp_value, 32'h0);
      d[0] = 8'hD4;
      eacks = model_wr(8'(GBASE + 3), 1, d);
      do_write(8'(GBASE + 3), 1, d, acks);
      check("R9 group commit", grp_value, 32'hD4C3B2A1);

      // R5: write past the top register
      d = '{8'h5E, 8'h6F, 8'h77, 8'h88, 8'h00, 8'h00, 8'h00, 8'h00};
      eacks = model_wr(8'(NREGS - 2), 4, d);
      do_write(8'(NREGS - 2), 4, d, acks);
      check("R5 past-top acks", {22'b0, acks}, {22'b0, eacks});
      check_bank("R5 past-top contents");

      // R3: invalid pointer leaves the pointer where it was
      do_read(8'd5, 1, q);
      check("R7 combined read", {24'b0, q[0]}, {24'b0, model[5]});
      i_start(); wr_byte(dev_byte(1'b0), a); wr_byte(8'(NREGS), a); i_stop();
      check("R3 pointer 16 nack", {31'b0, a}, 32'h0);
      i_start(); wr_byte(dev_byte(1'b0), a); wr_byte(8'd200, a); i_stop();
      check("R3 pointer 200 nack", {31'b0, a}, 32'h0);
      i_start(); wr_byte(dev_byte(1'b1), a); rd_byte(1'b0, q[0]); i_stop();
      check("R3 pointer kept after invalid", {24'b0, q[0]}, {24'b0, model[6]});

      // R6: read running past the top
      do_read(8'(NREGS - 2), 4, q);
      for (int i = 0; i < 4; i++)
         check("R6 read past top", {24'b0, q[i]}, {24'b0, model_rd(NREGS - 2 + i)});

      // R8: STOP mid-byte, then repeated START mid-byte
      i_start(); wr_byte(dev_byte(1'b0), a); wr_byte(8'd3, a);
      for (int i = 0; i < 4; i++) send_bit(1'b1, 0);
      i_stop();
      cfg_idx = 8'd3; tick(1);
      check("R8 stop drops partial byte", {24'b0, cfg_data}, {24'b0, model[3]});
      i_start(); wr_byte(dev_byte(1'b0), a); wr_byte(8'd3, a);
      for (int i = 0; i < 5; i++) send_bit(1'b0, 0);
      i_start(); wr_byte(dev_byte(1'b1), a); rd_byte(1'b0, q[0]); i_stop();
      check("R8 R7 start mid-byte keeps pointer", {24'b0, q[0]}, {24'b0, model[3]});
      cfg_idx = 8'd3; tick(1);
      check("R8 start drops partial byte", {24'b0, cfg_data}, {24'b0, model[3]});

      // R10: filter on rejects glitches on both lines
      addr_sel = 1'b0;
      i_start(); wr_byte_g(dev_byte(1'b0), 2, a); wr_byte(8'd4, a);
      wr_byte_g(8'h5A, 1, a); i_stop();
      model[4] = 8'h5A;
      check("R10 filtered write acked", {31'b0, a}, 32'h1);
      cfg_idx = 8'd4; tick(1);
      check("R10 filtered write intact", {24'b0, cfg_data}, 32'h5A);
      // R10: filter off, the SCL pulse adds a leading zero bit: 0x5A becomes 0x2D
      addr_sel = 1'b1;
      i_start(); wr_byte(dev_byte(1'b0), a); wr_byte(8'd4, a);
      wr_byte_g(8'h5A, 1, a); i_stop();
      model[4] = 8'h2D;
      cfg_idx = 8'd4; tick(1);
      check("R10 unfiltered glitch shifts byte", {24'b0, cfg_data}, 32'h2D);

      // R11: side port out of range
      cfg_idx = 8'd200; tick(1);
      check("R11 out-of-range index", {24'b0, cfg_data}, 32'h0);

      // random bursts in both filter modes
      for (int it = 0; it < 10; it++) begin
         logic [7:0] sub;
         int n;
         addr_sel = 1'($urandom % 2);
         sub = 8'($urandom % (NREGS + 2));
         n = 1 + int'($urandom % 4);
         for (int i = 0; i < 8; i++) d[i] = 8'($urandom);
         eacks = model_wr(sub, n, d);
         do_write(sub, n, d, acks);
         check("R3 R4 R5 random write acks", {22'b0, acks}, {22'b0, eacks});
         sub = 8'($urandom % NREGS);
         n = 1 + int'($urandom % 3);
         do_read(sub, n, q);
         for (int i = 0; i < n; i++)
            check("R6 random read", {24'b0, q[i]}, {24'b0, model_rd(int'(sub) + i)});
      end
      check_bank("R4 R9 R11 final bank");

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule